// File: doc/BRIEF.md
# Endpoint Configuration Bank and Buffer Allocator

This block sits behind the byte-wide command/data port of a USB device controller. It holds sixteen configuration bytes, one for each endpoint slot: slot 0 is the control OUT endpoint, slot 1 is the control IN endpoint, and slots 2 to 15 are endpoints 1 to 14. From these bytes it lays out a shared packet buffer. The microprocessor sends a command byte (flagged by `in_is_cmd`) and then one data byte. A write command stores that data byte into the selected slot. A read command instead returns the slot's value on the read stream.

The layout is deferred. It runs only after all sixteen slots have been written in strict order, with slot 15 last. The control slots must be part of this order even though their settings are fixed. A serial walk then gives every slot a start offset and a length. A one-cycle done pulse marks the end of the walk, and a buffers-valid flag rises with it. Any write that alters a slot's enable or size drops buffers-valid for all endpoints at once. A USB bus reset clears every enable bit, drops buffers-valid and aborts any walk in progress.

Both byte interfaces use valid/ready. An input byte is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a read byte waits on the output, while a walk is starting or running, and during a bus reset. A read byte stays on `rd_byte` with `rd_valid` high until a cycle in which `rd_ready` is high. Control and status pins are plain levels or pulses.

Top module: `ep_cfg_alloc`

## Requirements
- R1: After `rst_n` is released, every slot reads back 0x00, `bufs_valid`, `alloc_ovf` and `alloc_done` are 0, and `in_ready` is 1.
- R2: A command byte 0x20+n followed by a data byte stores the data byte in slot n. A command byte 0x30+n places slot n's value on `rd_byte` with `rd_valid` high in the cycle after it is accepted. A command byte whose upper nibble is neither 2 nor 3 is ignored, and so is the data byte that follows it.
- R3: While `rd_valid` is high and `rd_ready` is low, `in_ready` is 0 and `rd_byte` holds its value. No slot write is taken while a walk is starting or running.
- R4: A walk starts only when slot 15 is written and slots 0 through 14 were written in order immediately before it. A write to any slot other than the expected next one breaks the order. A write to slot 0 always begins a new order.
- R5: Slot byte layout: bit 7 is the buffer enable, bit 6 the direction, bit 5 the double-buffer flag, bit 4 the isochronous flag and bits 3:0 the size code. Size codes 0 to 6 give 8<<code bytes, and codes 7 to 15 give 1023 bytes.
- R6: Buffers are packed in slot order from offset 0. A disabled slot gets length 0. A double-buffered slot gets twice its size. Each slot's base equals the sum of the lengths of all lower slots.
- R7: `alloc_done` is high for exactly one cycle, on the 17th rising edge after the edge that takes the final data byte, and `bufs_valid` is 1 from that edge on.
- R8: `alloc_ovf` is set at the end of a walk whose total length exceeds MEM_DEPTH. It stays set until the next walk starts, which clears it.
- R9: A slot write that changes bit 7 or bits 3:0 pulses `inval_pulse` and clears `bufs_valid`. A write that changes only bits 6:4, or that changes nothing, leaves `bufs_valid` unchanged.
- R10: A one-cycle `usb_rst` clears bit 7 of every slot and keeps the other bits. It also clears `bufs_valid`, aborts a running walk without a done pulse, and restarts the write order.
- R11: `dma_dir[n]` equals bit 6 of slot n, where 1 means a write transfer and 0 means a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_rst | input | 1 | USB bus reset seen, one-cycle pulse |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_is_cmd | input | 1 | Input byte is a command code (1) or a data byte (0) |
| in_byte | input | 8 | Input byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_byte | output | 8 | Slot value returned by a read command |
| inval_pulse | output | 1 | Buffer contents invalidated, one-cycle pulse |
| alloc_done | output | 1 | Layout walk finished, one-cycle pulse |
| bufs_valid | output | 1 | Current layout holds valid buffers |
| alloc_ovf | output | 1 | Last layout exceeded MEM_DEPTH (sticky) |
| ep_base | output | 16*AW | Start offset per slot, slot n at bits [n*AW +: AW] |
| ep_len | output | 16*12 | Length in bytes per slot, slot n at bits [n*12 +: 12] |
| dma_dir | output | 16 | DMA direction per slot |

## Verification
The hardest case to reach from the ports is a bus reset that lands in the middle of a walk. At that moment the input port is closed, so only the reset pin can act. The bench finishes a complete ordered write pass, counts a few cycles into the walk, and then pulses `usb_rst`. It checks that no done pulse follows and that buffers-valid stays low. Broken write orders are built on purpose: a slot is rewritten partway through, and the order is restarted from slot 0. Fixed-seed random passes then cover the mixes of enable, double-buffer and size code, including totals above the memory depth.

// File: rtl/epcfg_pkg.sv
package epcfg_pkg;
  localparam int NUM_EP = 16;
  localparam int IDX_W  = $clog2(NUM_EP);
  localparam int LEN_W  = 12;

  localparam int B_EN  = 7;
  localparam int B_DIR = 6;
  localparam int B_DBL = 5;

  localparam logic [3:0] OP_WRITE = 4'h2;
  localparam logic [3:0] OP_READ  = 4'h3;

  function automatic logic [LEN_W-1:0] code_bytes(input logic [3:0] code);
    logic [LEN_W-1:0] b;
    if (code >= 4'd7) b = LEN_W'(1023);
    else              b = LEN_W'(8) << code;
    return b;
  endfunction

  function automatic logic [LEN_W-1:0] footprint(input logic [7:0] cfg);
    logic [LEN_W-1:0] b;
    b = code_bytes(cfg[3:0]);
    if (!cfg[B_EN])      return '0;
    else if (cfg[B_DBL]) return b << 1;
    else                 return b;
  endfunction
endpackage

// File: rtl/ep_cmd_port.sv
module ep_cmd_port
  import epcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_rst,
  input  logic             hold,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_cmd,
  input  logic [7:0]       in_byte,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_byte
);
  logic             pend_wr;
  logic [IDX_W-1:0] pend_idx;
  logic             take;

  assign in_ready = !hold && !usb_rst && !rd_valid;
  assign take     = in_valid && in_ready;
  assign rd_idx   = in_byte[IDX_W-1:0];
  assign wr_en    = take && !in_is_cmd && pend_wr;
  assign wr_idx   = pend_idx;
  assign wr_data  = in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr  <= 1'b0;
      pend_idx <= '0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (take) begin
        if (in_is_cmd) begin
          pend_wr  <= (in_byte[7:4] == OP_WRITE);
          pend_idx <= in_byte[IDX_W-1:0];
          if (in_byte[7:4] == OP_READ) begin
            rd_valid <= 1'b1;
            rd_byte  <= rd_data;
          end
        end else begin
          pend_wr <= 1'b0;
        end
      end
    end
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_byte));

  // R3
  no_wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !wr_en);
endmodule

// File: rtl/ep_cfg_bank.sv
module ep_cfg_bank
  import epcfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                usb_rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [7:0]          wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [7:0]          rd_data,
  output logic [NUM_EP*8-1:0] cfg_flat,
  output logic [NUM_EP-1:0]   dir_vec,
  output logic                start_pulse,
  output logic                inval_pulse
);
  logic [7:0]       slot [NUM_EP];
  logic [IDX_W-1:0] seq_next;
  logic [7:0]       old_val;
  logic             layout_chg;
  logic [NUM_EP-1:0] en_vec;

  assign rd_data    = slot[rd_idx];
  assign old_val    = slot[wr_idx];
  assign layout_chg = (old_val[B_EN] != wr_data[B_EN]) || (old_val[3:0] != wr_data[3:0]);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_flat
    assign cfg_flat[g*8 +: 8] = slot[g];
    assign dir_vec[g]         = slot[g][B_DIR];
    assign en_vec[g]          = slot[g][B_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EP; i++) slot[i] <= '0;
      seq_next    <= '0;
      start_pulse <= 1'b0;
      inval_pulse <= 1'b0;
    end else if (usb_rst) begin
      for (int i = 0; i < NUM_EP; i++) slot[i][B_EN] <= 1'b0;
      seq_next    <= '0;
      start_pulse <= 1'b0;
      inval_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      inval_pulse <= 1'b0;
      if (wr_en) begin
        slot[wr_idx] <= wr_data;
        inval_pulse  <= layout_chg;
        if (wr_idx == seq_next) begin
          if (seq_next == IDX_W'(NUM_EP-1)) begin
            start_pulse <= 1'b1;
            seq_next    <= '0;
          end else begin
            seq_next <= seq_next + 1'b1;
          end
        end else begin
          seq_next <= (wr_idx == '0) ? IDX_W'(1) : '0;
        end
      end
    end
  end

  // R10
  bus_rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rst |=> en_vec == '0);

  // R4
  start_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(wr_en) && $past(wr_idx) == IDX_W'(NUM_EP-1));
endmodule

// File: rtl/ep_alloc_walk.sv
module ep_alloc_walk
  import epcfg_pkg::*;
#(
  parameter int MEM_DEPTH = 4096,
  parameter int AW        = 16
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    usb_rst,
  input  logic                    start,
  input  logic                    inval,
  input  logic [NUM_EP*8-1:0]     cfg_flat,
  output logic                    busy,
  output logic                    alloc_done,
  output logic                    bufs_valid,
  output logic                    alloc_ovf,
  output logic [NUM_EP*AW-1:0]    base_flat,
  output logic [NUM_EP*LEN_W-1:0] len_flat
);
  logic [7:0]       cfg_a  [NUM_EP];
  logic [AW-1:0]    base_r [NUM_EP];
  logic [LEN_W-1:0] len_r  [NUM_EP];
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    acc;
  logic [LEN_W-1:0] fp;
  logic [AW:0]      nxt;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_map
    assign cfg_a[g]                   = cfg_flat[g*8 +: 8];
    assign base_flat[g*AW +: AW]      = base_r[g];
    assign len_flat[g*LEN_W +: LEN_W] = len_r[g];
  end

  assign fp  = footprint(cfg_a[idx]);
  assign nxt = {1'b0, acc} + (AW+1)'(fp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      alloc_done <= 1'b0;
      bufs_valid <= 1'b0;
      alloc_ovf  <= 1'b0;
      idx        <= '0;
      acc        <= '0;
      for (int i = 0; i < NUM_EP; i++) begin
        base_r[i] <= '0;
        len_r[i]  <= '0;
      end
    end else begin
      alloc_done <= 1'b0;
      if (usb_rst) begin
        busy       <= 1'b0;
        bufs_valid <= 1'b0;
      end else if (start) begin
        busy       <= 1'b1;
        idx        <= '0;
        acc        <= '0;
        alloc_ovf  <= 1'b0;
        bufs_valid <= 1'b0;
      end else begin
        if (inval) bufs_valid <= 1'b0;
        if (busy) begin
          base_r[idx] <= acc;
          len_r[idx]  <= fp;
          acc         <= nxt[AW-1:0];
          if (idx == IDX_W'(NUM_EP-1)) begin
            busy       <= 1'b0;
            alloc_done <= 1'b1;
            bufs_valid <= 1'b1;
            alloc_ovf  <= (nxt > (AW+1)'(MEM_DEPTH));
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |=> !alloc_done);

  // R7
  valid_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> bufs_valid);

  // R9
  inval_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval && !start |=> !bufs_valid);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ovf && !start |=> alloc_ovf);
endmodule

// File: rtl/ep_cfg_alloc.sv
module ep_cfg_alloc
  import epcfg_pkg::*;
#(
  parameter int MEM_DEPTH = 4096,
  parameter int AW        = 16
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    usb_rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_is_cmd,
  input  logic [7:0]              in_byte,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [7:0]              rd_byte,
  output logic                    inval_pulse,
  output logic                    alloc_done,
  output logic                    bufs_valid,
  output logic                    alloc_ovf,
  output logic [NUM_EP*AW-1:0]    ep_base,
  output logic [NUM_EP*LEN_W-1:0] ep_len,
  output logic [NUM_EP-1:0]       dma_dir
);
  logic             walk_busy, start_pulse, hold;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;
  logic [NUM_EP*8-1:0] cfg_flat;

  assign hold = walk_busy || start_pulse;

  ep_cmd_port u_port (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst), .hold(hold),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte)
  );

  ep_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .cfg_flat(cfg_flat), .dir_vec(dma_dir),
    .start_pulse(start_pulse), .inval_pulse(inval_pulse)
  );

  ep_alloc_walk #(.MEM_DEPTH(MEM_DEPTH), .AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
    .start(start_pulse), .inval(inval_pulse), .cfg_flat(cfg_flat),
    .busy(walk_busy), .alloc_done(alloc_done), .bufs_valid(bufs_valid),
    .alloc_ovf(alloc_ovf), .base_flat(ep_base), .len_flat(ep_len)
  );
endmodule

// File: tb/sim_ep_cfg_alloc.sv
module sim_ep_cfg_alloc;
  localparam int MEMD = 4096;
  localparam int AW   = 16;
  localparam int LW   = 12;
  localparam int NE   = 16;

  logic clk = 1'b0, rst_n = 1'b0, usb_rst = 1'b0;
  logic in_valid = 1'b0, in_is_cmd = 1'b0, rd_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, rd_valid, inval_pulse, alloc_done, bufs_valid, alloc_ovf;
  logic [7:0] rd_byte;
  logic [NE*AW-1:0] ep_base;
  logic [NE*LW-1:0] ep_len;
  logic [NE-1:0]    dma_dir;

  ep_cfg_alloc #(.MEM_DEPTH(MEMD), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
    .inval_pulse(inval_pulse), .alloc_done(alloc_done), .bufs_valid(bufs_valid),
    .alloc_ovf(alloc_ovf), .ep_base(ep_base), .ep_len(ep_len), .dma_dir(dma_dir)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, inval_cnt = 0;
  bit finished = 0;
  logic [7:0] m_reg [NE];

  always @(negedge clk) if (inval_pulse) inval_cnt++;

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_fp(logic [7:0] c);
    int b;
    b = (c[3:0] >= 7) ? 1023 : (8 << c[3:0]);
    if (!c[7]) return 0;
    return c[5] ? 2*b : b;
  endfunction

  task automatic send(logic [7:0] b, logic cmd);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_cmd = cmd;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(int n, logic [7:0] v);
    send(8'h20 + 8'(n), 1'b1);
    send(v, 1'b0);
    m_reg[n] = v;
  endtask

  task automatic rd(int n, output logic [7:0] v);
    send(8'h30 + 8'(n), 1'b1);
    check("R2", "rd_valid after read cmd", rd_valid, 1);
    v = rd_byte;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!alloc_done && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic check_layout();
    int acc = 0;
    for (int i = 0; i < NE; i++) begin
      check("R6", $sformatf("base slot %0d", i), ep_base[i*AW +: AW], acc);
      check("R5", $sformatf("len slot %0d", i), ep_len[i*LW +: LW], exp_fp(m_reg[i]));
      acc += exp_fp(m_reg[i]);
    end
    check("R8", "overflow flag", alloc_ovf, (acc > MEMD) ? 1 : 0);
    check("R7", "bufs_valid after walk", bufs_valid, 1);
  endtask

  task automatic run_config(bit timed);
    int n;
    for (int i = 0; i < NE; i++) wr(i, m_reg[i]);
    wait_done(n);
    if (timed) check("R7", "cycles to done", n, 17);
    else       check("R7", "done seen", (n < 40) ? 1 : 0, 1);
    @(negedge clk);
    check("R7", "done is one cycle", alloc_done, 0);
    check_layout();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, c0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NE; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "bufs_valid", bufs_valid, 0);
    check("R1", "alloc_ovf", alloc_ovf, 0);
    check("R1", "alloc_done", alloc_done, 0);
    check("R1", "in_ready", in_ready, 1);
    for (int i = 0; i < NE; i += 5) begin rd(i, v); check("R1", "slot reset", v, 0); end

    // directed layout: sizes, disabled slot, double buffer, large codes
    m_reg[0] = 8'h83; m_reg[1] = 8'hC3; m_reg[2] = 8'hA5; m_reg[3] = 8'h05;
    m_reg[4] = 8'hD7; m_reg[5] = 8'h89; m_reg[6] = 8'h90; m_reg[7] = 8'hE1;
    run_config(1);
    for (int i = 0; i < NE; i++) check("R11", "dma_dir", dma_dir[i], m_reg[i][6]);
    for (int i = 0; i < NE; i++) begin rd(i, v); check("R2", "readback", v, m_reg[i]); end

    // R3 back-pressure on read stream
    send(8'h32, 1'b1);
    for (int k = 0; k < 3; k++) begin
      check("R3", "in_ready held low", in_ready, 0);
      check("R3", "rd_byte held", rd_byte, m_reg[2]);
      @(negedge clk);
    end
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    check("R3", "in_ready after drain", in_ready, 1);

    // R2 unknown command and stray data ignored
    send(8'h45, 1'b1); send(8'hFF, 1'b0);
    send(8'h7E, 1'b0);
    rd(5, v); check("R2", "slot 5 untouched", v, m_reg[5]);
    check("R9", "valid kept after ignored bytes", bufs_valid, 1);

    // R9 direction-only change keeps valid; size change invalidates
    c0 = inval_cnt;
    wr(3, 8'h75);
    repeat (2) @(negedge clk);
    check("R9", "valid after bits 6:4 change", bufs_valid, 1);
    check("R9", "no inval pulse", inval_cnt - c0, 0);
    wr(3, 8'h76);
    repeat (2) @(negedge clk);
    check("R9", "valid after size change", bufs_valid, 0);
    check("R9", "one inval pulse", inval_cnt - c0, 1);

    // R4 broken order: slot 3 rewritten mid-sequence
    for (int i = 0; i < 8; i++) wr(i, m_reg[i]);
    wr(3, m_reg[3]);
    for (int i = 8; i < NE; i++) wr(i, m_reg[i]);
    wait_done(n);
    check("R4", "no walk after broken order", (n < 40) ? 1 : 0, 0);
    check("R4", "valid still low", bufs_valid, 0);
    // R4 restart from slot 0 midway
    for (int i = 0; i < 6; i++) wr(i, m_reg[i]);
    run_config(1);

    // R8 overflow then recovery
    for (int i = 0; i < NE; i++) m_reg[i] = 8'hA7;
    run_config(1);
    check("R8", "overflow set", alloc_ovf, 1);
    for (int i = 0; i < NE; i++) m_reg[i] = (i < 4) ? 8'h84 : 8'h00;
    run_config(1);
    check("R8", "overflow cleared", alloc_ovf, 0);

    // R10 bus reset after valid layout
    @(negedge clk); usb_rst = 1'b1; @(negedge clk); usb_rst = 1'b0;
    check("R10", "valid cleared", bufs_valid, 0);
    for (int i = 0; i < NE; i++) m_reg[i][7] = 1'b0;
    for (int i = 0; i < 4; i++) begin rd(i, v); check("R10", "enable cleared", v, m_reg[i]); end

    // R10 bus reset in the middle of a walk
    for (int i = 0; i < NE; i++) m_reg[i] = 8'h82;
    for (int i = 0; i < NE; i++) wr(i, m_reg[i]);
    repeat (5) @(negedge clk);
    usb_rst = 1'b1; @(negedge clk); usb_rst = 1'b0;
    wait_done(n);
    check("R10", "walk aborted", (n < 40) ? 1 : 0, 0);
    check("R10", "valid low after abort", bufs_valid, 0);
    for (int i = 0; i < NE; i++) m_reg[i][7] = 1'b0;
    rd(9, v); check("R10", "slot 9 after abort", v, m_reg[9]);

    // random passes
    for (int p = 0; p < 8; p++) begin
      int s;
      for (int i = 0; i < NE; i++) begin
        m_reg[i] = 8'($urandom);
        if (($urandom % 3) == 0) m_reg[i][7] = 1'b0;
      end
      run_config(1);
      for (int i = 0; i < NE; i++) check("R11", "dma_dir random", dma_dir[i], m_reg[i][6]);
      s = $urandom % NE;
      rd(s, v); check("R2", "random readback", v, m_reg[s]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule